// File: doc/BRIEF.md
# Frame-Aligned Serial Audio Receiver

This block receives two-channel serial audio in the I2S format. A bit clock, a word-select (frame sync) line and a data line come in synchronous to the system clock and are oversampled at four or more system clocks per bit. Each word is sampled on the rising bit clock, starting with the MSB one bit period after word select changes. The first 24 bits of the slot are kept, and the completed word is pushed into an 8-entry FIFO, placed in the upper bits of a 32-bit entry.

Capture does not start at the moment the port is enabled. The port first waits for the word-select transition that opens a left slot. Because of this, the first word it stores is always a left sample, and left and right then alternate, whatever the phase at which software sets the enable. Clearing the enable empties the FIFO, clears the overflow flag and sets up this wait again.

A threshold interrupt signals when FIFO occupancy becomes greater than a programmed value N. Two edge-mask bits gate it, and a priority bit sends it to either a high-priority or a low-priority output.

Top module: `i2s_rx_port`

## Requirements
- R1: On each rising bit clock the data line is sampled. The MSB comes in the period after a word-select change, and the first 24 bits of the slot form the word. The word is stored as bits [31:8] of the FIFO entry, with bits [7:0] zero and later bits of the slot ignored.
- R2: Once `cfg_en` is set, nothing is stored until word select goes from 1 to 0 (the start of a left slot). From then on the stored order is left, right, left, right, with word select 0 meaning left.
- R3: While `cfg_en` is 0, no word is stored. Driving `cfg_en` to 0 empties the FIFO (count 0) and clears `overflow` on the next clock.
- R4: `cfg_ch_en[0]` allows left words and `cfg_ch_en[1]` allows right words to be stored. A word whose channel bit is 0 is discarded.
- R5: The FIFO holds 8 entries in first-in first-out order. `rd_data` shows the oldest entry whenever `rd_valid` is 1, `rd_en` pops it, and `fifo_count` gives the occupancy.
- R6: A word that arrives while the FIFO is full is dropped and sets `overflow`. The flag stays set until `cfg_en` is cleared.
- R7: When `fifo_count` goes from at most `cfg_thresh` to greater than `cfg_thresh`, exactly one one-cycle interrupt pulse is produced. This happens only when `cfg_mask_rise`=1 and `cfg_mask_fall`=0; any other mask setting produces no pulse.
- R8: The pulse goes out on `irq_hi` when `cfg_prio`=1 and on `irq_lo` when `cfg_prio`=0, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_in | input | 1 | Serial bit clock, oversampled |
| ws_in | input | 1 | Word select / frame sync, 0 = left |
| sd_in | input | 1 | Serial data, MSB first |
| cfg_en | input | 1 | Global port enable |
| cfg_ch_en | input | 2 | Channel enables, bit 0 left, bit 1 right |
| cfg_thresh | input | 3 | Threshold N for the occupancy interrupt |
| cfg_mask_rise | input | 1 | Rising-edge interrupt mask (1 = unmasked) |
| cfg_mask_fall | input | 1 | Falling-edge interrupt mask (must be 0 to fire) |
| cfg_prio | input | 1 | Interrupt priority select, 1 = high |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 32 | Oldest FIFO entry, word left-justified |
| rd_valid | output | 1 | FIFO not empty |
| fifo_count | output | 4 | FIFO occupancy, 0 to 8 |
| overflow | output | 1 | Sticky flag for a dropped word |
| irq_hi | output | 1 | High-priority threshold interrupt pulse |
| irq_lo | output | 1 | Low-priority threshold interrupt pulse |

## Verification
Some rules are checked by the assertions on every cycle: the occupancy bound, the flush one cycle after the enable drops, the overflow flag holding, the two interrupt outputs never being high together, the interrupt firing only with the unmasking pattern and the matching priority, and each interrupt lasting a single cycle. Other behaviour can only be shown by the bench's scenarios. These are the start-of-capture alignment, swept across every phase class of the enable within a frame, the MSB-first bit extraction and left-justified packing, the channel enables, and the exact number of interrupt pulses for every threshold value from 0 to 7.

// File: rtl/i2s_rx_port.sv
module i2s_rx_port #(
  parameter int WORD_W  = 24,
  parameter int ENTRY_W = 32,
  parameter int DEPTH   = 8,
  parameter int N_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_in,
  input  logic                     ws_in,
  input  logic                     sd_in,
  input  logic                     cfg_en,
  input  logic [1:0]               cfg_ch_en,
  input  logic [N_W-1:0]           cfg_thresh,
  input  logic                     cfg_mask_rise,
  input  logic                     cfg_mask_fall,
  input  logic                     cfg_prio,
  input  logic                     rd_en,
  output logic [ENTRY_W-1:0]       rd_data,
  output logic                     rd_valid,
  output logic [$clog2(DEPTH):0]   fifo_count,
  output logic                     overflow,
  output logic                     irq_hi,
  output logic                     irq_lo
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int BW  = $clog2(WORD_W + 1);
  localparam int PAD = ENTRY_W - WORD_W;

  logic              sclk_q, ws_prev, armed, above_q;
  logic [BW-1:0]     bit_cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  wire sclk_rise = sclk_in & ~sclk_q;
  wire fs_edge   = sclk_rise & (ws_in ^ ws_prev);
  wire arm_edge  = fs_edge & ~ws_in;
  wire taking    = bit_cnt < BW'(WORD_W);
  wire [WORD_W-1:0] word_nx = taking ? {sh[WORD_W-2:0], sd_in} : sh;

  wire wr_req = cfg_en & armed & fs_edge & cfg_ch_en[ws_prev];
  wire full   = fifo_count == CW'(DEPTH);
  wire push   = wr_req & ~full;
  wire pop    = rd_en & rd_valid;
  wire above  = fifo_count > CW'(cfg_thresh);
  wire fire   = above & ~above_q & cfg_mask_rise & ~cfg_mask_fall;

  assign rd_valid = fifo_count != '0;
  assign rd_data  = {mem[rptr], {PAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      ws_prev <= 1'b1;
      bit_cnt <= BW'(WORD_W);
      sh      <= '0;
    end else begin
      sclk_q <= sclk_in;
      if (sclk_rise) begin
        ws_prev <= ws_in;
        if (fs_edge) begin
          bit_cnt <= '0;
          sh      <= '0;
        end else if (taking) begin
          bit_cnt <= bit_cnt + BW'(1);
          sh      <= word_nx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      wptr       <= '0;
      rptr       <= '0;
      fifo_count <= '0;
      overflow   <= 1'b0;
    end else if (!cfg_en) begin
      armed      <= 1'b0;
      wptr       <= '0;
      rptr       <= '0;
      fifo_count <= '0;
      overflow   <= 1'b0;
    end else begin
      if (arm_edge) armed <= 1'b1;
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      fifo_count <= fifo_count + CW'(push) - CW'(pop);
      if (wr_req && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= word_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      irq_hi  <= 1'b0;
      irq_lo  <= 1'b0;
    end else begin
      above_q <= above;
      irq_hi  <= fire & cfg_prio;
      irq_lo  <= fire & ~cfg_prio;
    end
  end
endmodule

// File: rtl/i2s_rx_port_chk.sv
module i2s_rx_port_chk #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_en,
  input logic                   cfg_mask_rise,
  input logic                   cfg_mask_fall,
  input logic                   cfg_prio,
  input logic [$clog2(DEPTH):0] fifo_count,
  input logic                   overflow,
  input logic                   irq_hi,
  input logic                   irq_lo
);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (fifo_count == '0 && !overflow));

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && cfg_en) |=> overflow);

  a_r8_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_hi && irq_lo));

  a_r8_hi_prio: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> $past(cfg_prio));

  a_r8_lo_prio: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> !$past(cfg_prio));

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi || irq_lo) |-> $past(cfg_mask_rise && !cfg_mask_fall));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi || irq_lo) |=> !(irq_hi || irq_lo));
endmodule

bind i2s_rx_port i2s_rx_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
  .cfg_mask_rise(cfg_mask_rise), .cfg_mask_fall(cfg_mask_fall),
  .cfg_prio(cfg_prio), .fifo_count(fifo_count), .overflow(overflow),
  .irq_hi(irq_hi), .irq_lo(irq_lo)
);

// File: tb/sim_i2s_rx_port.sv
module sim_i2s_rx_port;
  localparam int CLK_NS = 10;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, ws_in = 1'b1, sd_in = 1'b1;
  logic cfg_en = 1'b0, cfg_mask_rise = 1'b0, cfg_mask_fall = 1'b0, cfg_prio = 1'b0;
  logic [1:0] cfg_ch_en = 2'b11;
  logic [2:0] cfg_thresh = 3'd0;
  logic rd_en = 1'b0;
  logic [31:0] rd_data;
  logic rd_valid, overflow, irq_hi, irq_lo;
  logic [3:0] fifo_count;

  int checks = 0, errors = 0, nhi = 0, nlo = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) begin
    if (irq_hi) nhi++;
    if (irq_lo) nlo++;
  end

  i2s_rx_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .cfg_en(cfg_en), .cfg_ch_en(cfg_ch_en), .cfg_thresh(cfg_thresh),
    .cfg_mask_rise(cfg_mask_rise), .cfg_mask_fall(cfg_mask_fall), .cfg_prio(cfg_prio),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .fifo_count(fifo_count),
    .overflow(overflow), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  function automatic logic [23:0] mkw(input int s, input int k);
    return 24'(32'h00A5C3 + s * 32'h13579 + k * 32'h2468B) ^ 24'h800001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bclk(input logic ws, input logic sd);
    sclk_in = 1'b0; ws_in = ws; sd_in = sd;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int p);
    for (int i = 0; i < 64; i++) begin
      int j;
      logic [23:0] w;
      j = i % 32;
      w = (i < 32) ? l : r;
      if (i == p) cfg_en = 1'b1;
      bclk(i >= 32, (j >= 1 && j <= 24) ? w[24-j] : 1'b1);
    end
  endtask

  task automatic tail();
    bclk(1'b0, 1'b1);
    bclk(1'b0, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic restart();
    cfg_en = 1'b0;
    @(negedge clk);
    bclk(1'b1, 1'b1);
    bclk(1'b1, 1'b1);
  endtask

  task automatic pop_check(input string req, input logic [23:0] w);
    chk({req, " valid"}, 32'(rd_valid), 32'd1);
    chk(req, rd_data, {w, 8'h00});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ps[7];
    ps = '{0, 1, 5, 31, 32, 33, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset count", 32'(fifo_count), 32'd0);
    chk("R5 reset valid", 32'(rd_valid), 32'd0);
    chk("R6 reset overflow", 32'(overflow), 32'd0);
    chk("R8 reset irq", {30'd0, irq_hi, irq_lo}, 32'd0);

    // R3: disabled port stores nothing
    restart();
    send_frame(mkw(99, 0), mkw(99, 1), -1);
    send_frame(mkw(99, 2), mkw(99, 3), -1);
    tail();
    chk("R3 disabled stores nothing", 32'(fifo_count), 32'd0);

    // R1 R2: sweep enable phase through the frame
    for (int t = 0; t < 7; t++) begin
      int k0;
      restart();
      send_frame(mkw(t, 0), mkw(t, 1), ps[t]);
      send_frame(mkw(t, 2), mkw(t, 3), -1);
      send_frame(mkw(t, 4), mkw(t, 5), -1);
      tail();
      k0 = (ps[t] == 0) ? 0 : 2;
      chk("R2 aligned count", 32'(fifo_count), 32'(6 - k0));
      for (int k = k0; k < 6; k++) pop_check("R1 R2 word order", mkw(t, k));
      chk("R5 drained", 32'(rd_valid), 32'd0);
    end

    // R4: channel enables
    for (int c = 1; c <= 2; c++) begin
      restart();
      cfg_ch_en = 2'(c);
      send_frame(mkw(20 + c, 0), mkw(20 + c, 1), 0);
      send_frame(mkw(20 + c, 2), mkw(20 + c, 3), -1);
      tail();
      chk("R4 one channel count", 32'(fifo_count), 32'd2);
      pop_check("R4 channel word", mkw(20 + c, (c == 1) ? 0 : 1));
      pop_check("R4 channel word", mkw(20 + c, (c == 1) ? 2 : 3));
    end
    cfg_ch_en = 2'b11;

    // R6 R5 R3: overflow, order, flush
    restart();
    for (int f = 0; f < 5; f++) send_frame(mkw(30, 2*f), mkw(30, 2*f+1), (f == 0) ? 0 : -1);
    tail();
    chk("R5 full count", 32'(fifo_count), 32'd8);
    chk("R6 overflow set", 32'(overflow), 32'd1);
    pop_check("R5 fifo order", mkw(30, 0));
    pop_check("R5 fifo order", mkw(30, 1));
    chk("R6 overflow sticky", 32'(overflow), 32'd1);
    chk("R5 count after pops", 32'(fifo_count), 32'd6);
    cfg_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 flush count", 32'(fifo_count), 32'd0);
    chk("R3 flush overflow", 32'(overflow), 32'd0);

    // R7 R8: threshold sweep with priority
    for (int n = 0; n < 8; n++) begin
      int h0, l0;
      cfg_thresh = 3'(n);
      cfg_prio = n[0];
      cfg_mask_rise = 1'b1;
      cfg_mask_fall = 1'b0;
      restart();
      h0 = nhi; l0 = nlo;
      for (int f = 0; f < 4; f++) send_frame(mkw(40, 2*f), mkw(40, 2*f+1), (f == 0) ? 0 : -1);
      tail();
      chk("R5 count at 8", 32'(fifo_count), 32'd8);
      chk("R7 R8 hi pulses", 32'(nhi - h0), 32'(n[0]));
      chk("R7 R8 lo pulses", 32'(nlo - l0), 32'(!n[0]));
    end

    // R7: other mask patterns stay silent
    for (int m = 0; m < 3; m++) begin
      int h0, l0;
      cfg_thresh = 3'd2;
      cfg_prio = m[0];
      cfg_mask_rise = (m == 2);
      cfg_mask_fall = (m != 0);
      restart();
      h0 = nhi; l0 = nlo;
      for (int f = 0; f < 4; f++) send_frame(mkw(50, 2*f), mkw(50, 2*f+1), (f == 0) ? 0 : -1);
      tail();
      chk("R7 masked no irq", 32'((nhi - h0) + (nlo - l0)), 32'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule